// File: doc/BRIEF.md
# Programmable Serial Peripheral Port

This block is a byte-wide synchronous serial port that a processor controls through three registers: control, status and data. As bus master it generates the serial clock from the system clock through a fixed divider and drives an active-low select line for the length of each byte. As a slave it is clocked by an external master, and a select input enables its shift engine. Bit order, clock idle level and sampling phase can be set by software.

A byte written to the data register while the port is idle starts a transfer (master) or becomes the byte returned to the external master (slave). When the eighth bit has been exchanged, a completion flag is raised and the received byte can be read from the data register. A data write that arrives while a transfer is running is dropped and sets a collision flag. The completion flag, the interrupt-enable control bit and an external serial-interrupt enable together drive a single request output. Slave inputs pass through a synchronizer, so in slave mode the external clock must be several times slower than the system clock.

Top module: `spi_port`

## Requirements
- R1: After reset the control register reads 0x00, status bits 7 and 6 read 0, `ss_no` is 1, `irq_o` is 0 and no output enable is asserted. Addresses: 0 = control, 1 = status, 2 = data. Control bits, from 7 down to 0: interrupt enable, port enable, LSB-first, master, clock polarity, clock phase, rate[1:0].
- R2: In master mode with the port enabled, a data write while idle starts one 8-bit transfer. `ss_no` is low for the whole transfer, and the byte shifted in on `miso_i` is then returned by a data-register read.
- R3: When the LSB-first bit is 0, the most significant bit goes out first. When it is 1, the least significant bit goes out first. This holds for both directions.
- R4: When the port is idle, `sck_o` sits at the clock-polarity level. With phase 0, data is sampled on the leading SCK edge and changes on the trailing edge. With phase 1, data changes on the leading edge and is sampled on the trailing edge.
- R5: In master mode, rate codes 0, 1, 2 and 3 give an SCK half-period of 2, 8, 32 and 64 system clocks (divide by 4, 16, 64 and 128).
- R6: Status bit 7 is set when a transfer ends. It is cleared only by a status write with bit 7 = 0; a status write with bit 7 = 1 leaves it set.
- R7: A data write during a transfer sets status bit 6 and is discarded, so the byte in flight is sent unchanged. Bit 6 is cleared only by a status write with bit 6 = 0.
- R8: `irq_o` is 1 exactly when status bit 7, the interrupt-enable bit and `ser_int_en_i` are all 1.
- R9: In slave mode the port exchanges a byte with an external master clocking `sck_i` while `ss_ni` is low. It returns the byte last written to the data register and captures the `mosi_i` byte.
- R10: `miso_oe_o` is 1 only when the port is enabled in slave mode and `ss_ni` is low.
- R11: When the port-enable bit is 0, a data write starts no transfer, `ss_no` stays 1 and the SCK, MOSI and MISO output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the selected address |
| ser_int_en_i | input | 1 | External serial-interrupt enable |
| irq_o | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe_o | output | 1 | Output enable for sck_o |
| mosi_i | input | 1 | Serial data in, slave mode |
| mosi_o | output | 1 | Serial data out, master mode |
| mosi_oe_o | output | 1 | Output enable for mosi_o |
| miso_i | input | 1 | Serial data in, master mode |
| miso_o | output | 1 | Serial data out, slave mode |
| miso_oe_o | output | 1 | Output enable for miso_o; 0 means high impedance |
| ss_ni | input | 1 | Slave select, active low |
| ss_no | output | 1 | Slave select driven in master mode, active low |

## Verification
The bound checker checks these properties on every cycle: the completion flag holds until a clearing status write, the collision flag is set by a write during a busy transfer, the master select falls only after a data write, SCK stays still while the port is idle, the disabled port drives nothing, and the interrupt request never appears without the external enable. Only the bench scenarios can show the actual bits exchanged in each bit order and in all four clock modes, the exact half-period for every rate code, that a colliding byte is discarded, and a complete slave exchange with an external master.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam int DIV_W = 7;

  typedef struct packed {
    logic       irq_en;
    logic       en;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  // SCK half period in system clocks
  function automatic logic [DIV_W-1:0] half_period(input logic [1:0] rate);
    case (rate)
      2'd0:    half_period = DIV_W'(2);
      2'd1:    half_period = DIV_W'(8);
      2'd2:    half_period = DIV_W'(32);
      default: half_period = DIV_W'(64);
    endcase
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] rst_val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= rst_val_i;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div
  import spi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] rate_i,
  output logic       tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;

  assign last   = half_period(rate_i) - DIV_W'(1);
  assign tick_o = run_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         lsb_first_i,
  input  logic         cpha_i,
  input  logic         lead_i,
  input  logic         trail_i,
  input  logic         sdi_i,
  output logic         sdo_o,
  output logic         done_o,
  output logic [W-1:0] data_o
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             samp_q, out_q, done_q;
  logic             sr_end, shift_in;
  logic [W-1:0]     sr_shifted;

  assign sr_end     = lsb_first_i ? sr_q[0] : sr_q[W-1];
  assign shift_in   = cpha_i ? sdi_i : samp_q;
  assign sr_shifted = lsb_first_i ? {shift_in, sr_q[W-1:1]} : {sr_q[W-2:0], shift_in};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      samp_q <= 1'b0;
      out_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) sr_q <= load_data_i;
      if (clear_i) begin
        cnt_q <= '0;
      end else begin
        if (lead_i) begin
          if (cpha_i) out_q  <= sr_end;
          else        samp_q <= sdi_i;
        end
        if (trail_i) begin
          sr_q <= sr_shifted;
          if (cnt_q == CNT_W'(W - 1)) begin
            cnt_q  <= '0;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
      end
    end
  end

  assign sdo_o  = cpha_i ? out_q : sr_end;
  assign done_o = done_q;
  assign data_o = sr_q;
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] reg_addr_i,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       ser_int_en_i,
  output logic       irq_o,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe_o,
  input  logic       mosi_i,
  output logic       mosi_o,
  output logic       mosi_oe_o,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe_o,
  input  logic       ss_ni,
  output logic       ss_no
);
  localparam int W = 8;

  ctrl_t        ctrl_q;
  logic         spif_q, wcol_q, m_busy_q, s_busy_q, sck_q, s_sck_d_q;
  logic [W-1:0] rxbuf_q, sr_data;
  logic         wr_ctrl, wr_stat, wr_data;
  logic         m_mode, s_mode, busy, tick, m_lead, m_trail;
  logic         s_ss, s_sck, s_mosi, s_active, s_edge, s_lead, s_trail;
  logic         lead, trail, sdi, sdo, done, clear;
  logic [2:0]   sync_q;

  assign wr_ctrl = reg_wr_i && reg_addr_i == ADDR_CTRL;
  assign wr_stat = reg_wr_i && reg_addr_i == ADDR_STAT;
  assign wr_data = reg_wr_i && reg_addr_i == ADDR_DATA;
  assign m_mode  = ctrl_q.en && ctrl_q.master;
  assign s_mode  = ctrl_q.en && !ctrl_q.master;
  assign busy    = ctrl_q.master ? m_busy_q : s_busy_q;

  // master clock generation
  spi_clk_div u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (m_busy_q),
    .rate_i (ctrl_q.rate),
    .tick_o (tick)
  );

  assign m_lead  = tick && (sck_q == ctrl_q.cpol);
  assign m_trail = tick && (sck_q != ctrl_q.cpol);

  // slave inputs: {ss, sck, mosi}
  spi_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .d_i       ({ss_ni, sck_i, mosi_i}),
    .rst_val_i (3'b100),
    .q_o       (sync_q)
  );

  assign {s_ss, s_sck, s_mosi} = sync_q;
  assign s_active = s_mode && !s_ss;
  assign s_edge   = s_sck != s_sck_d_q;
  assign s_lead   = s_active && s_edge && (s_sck != ctrl_q.cpol);
  assign s_trail  = s_active && s_edge && (s_sck == ctrl_q.cpol);

  assign lead  = ctrl_q.master ? m_lead  : s_lead;
  assign trail = ctrl_q.master ? m_trail : s_trail;
  assign sdi   = ctrl_q.master ? miso_i  : s_mosi;
  assign clear = ctrl_q.master ? !m_busy_q : !s_active;

  spi_shifter #(.W(W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear),
    .load_i      (wr_data && !busy),
    .load_data_i (reg_wdata_i),
    .lsb_first_i (ctrl_q.lsb_first),
    .cpha_i      (ctrl_q.cpha),
    .lead_i      (lead),
    .trail_i     (trail),
    .sdi_i       (sdi),
    .sdo_o       (sdo),
    .done_o      (done),
    .data_o      (sr_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      spif_q    <= 1'b0;
      wcol_q    <= 1'b0;
      rxbuf_q   <= '0;
      m_busy_q  <= 1'b0;
      s_busy_q  <= 1'b0;
      sck_q     <= 1'b0;
      s_sck_d_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata_i);
      s_sck_d_q <= s_sck;

      if (!m_mode || done)              m_busy_q <= 1'b0;
      else if (wr_data && !m_busy_q)    m_busy_q <= 1'b1;

      if (!s_active || done)            s_busy_q <= 1'b0;
      else if (s_lead || s_trail)       s_busy_q <= 1'b1;

      if (!m_busy_q)  sck_q <= ctrl_q.cpol;
      else if (tick)  sck_q <= ~sck_q;

      if (done) rxbuf_q <= sr_data;
      // flags: set wins over a clearing write in the same cycle
      spif_q <= (spif_q && !(wr_stat && !reg_wdata_i[7])) || done;
      wcol_q <= (wcol_q && !(wr_stat && !reg_wdata_i[6])) || (wr_data && busy);
    end
  end

  always_comb begin
    case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o = ctrl_q;
      ADDR_STAT: reg_rdata_o = {spif_q, wcol_q, 6'b0};
      ADDR_DATA: reg_rdata_o = rxbuf_q;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign irq_o     = spif_q && ctrl_q.irq_en && ser_int_en_i;
  assign sck_o     = m_busy_q ? sck_q : ctrl_q.cpol;
  assign sck_oe_o  = m_mode;
  assign mosi_o    = sdo;
  assign mosi_oe_o = m_mode;
  assign miso_o    = sdo;
  assign miso_oe_o = s_mode && !ss_ni;
  assign ss_no     = !m_busy_q;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] reg_addr_i,
  input logic       reg_wr_i,
  input logic [7:0] reg_wdata_i,
  input logic       ser_int_en_i,
  input logic       irq_o,
  input logic       sck_o,
  input logic       sck_oe_o,
  input logic       mosi_oe_o,
  input logic       miso_oe_o,
  input logic       ss_no,
  input logic       en,
  input logic       cpol,
  input logic       spif,
  input logic       wcol,
  input logic       busy
);
  // R6
  spif_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spif && !(reg_wr_i && reg_addr_i == 2'd1 && !reg_wdata_i[7])) |=> spif);

  // R7
  wcol_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && reg_wr_i && reg_addr_i == 2'd2) |=> wcol);

  // R2
  ss_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ss_no) |-> $past(reg_wr_i && reg_addr_i == 2'd2));

  // R4
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_no && $past(ss_no) && $stable(cpol)) |-> $stable(sck_o));

  // R11
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (ss_no && !sck_oe_o && !mosi_oe_o && !miso_oe_o));

  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ser_int_en_i && spif));
endmodule

bind spi_port spi_port_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_addr_i   (reg_addr_i),
  .reg_wr_i     (reg_wr_i),
  .reg_wdata_i  (reg_wdata_i),
  .ser_int_en_i (ser_int_en_i),
  .irq_o        (irq_o),
  .sck_o        (sck_o),
  .sck_oe_o     (sck_oe_o),
  .mosi_oe_o    (mosi_oe_o),
  .miso_oe_o    (miso_oe_o),
  .ss_no        (ss_no),
  .en           (ctrl_q.en),
  .cpol         (ctrl_q.cpol),
  .spif         (spif_q),
  .wcol         (wcol_q),
  .busy         (busy)
);

// File: tb/spi_port_bench.sv
module spi_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ser_en = 1'b0;
  logic       irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_no;
  logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_ni = 1'b1;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  // bench-side slave model for master tests
  bit         mon_on = 0;
  logic       m_cpol = 0, m_cpha = 0, m_lsb = 0, prev_sck = 0, lead = 0;
  logic [7:0] bs_byte = 0, cap = 0;
  int         bs_k = 0, cap_k = 0, edge_n = 0, t_e1 = 0, t_e2 = 0;

  always #2.5 clk = ~clk;

  spi_port u_spi_port (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .ser_int_en_i(ser_en),
    .irq_o(irq), .sck_i(sck_i), .sck_o(sck_o), .sck_oe_o(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe), .miso_i(miso_i),
    .miso_o(miso_o), .miso_oe_o(miso_oe), .ss_ni(ss_ni), .ss_no(ss_no)
  );

  function automatic logic bit_at(input logic [7:0] b, input int k, input logic lsb);
    return lsb ? b[k] : b[7-k];
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  always @(negedge clk) begin
    if (mon_on && sck_o !== prev_sck) begin
      edge_n++;
      if (edge_n == 1) t_e1 = cyc;
      if (edge_n == 2) t_e2 = cyc;
      lead = (sck_o != m_cpol);
      if (lead ^ m_cpha) begin
        if (cap_k < 8) cap[m_lsb ? cap_k : 7-cap_k] = mosi_o;
        cap_k++;
      end else if (!m_cpha) begin
        bs_k++;
        if (bs_k < 8) miso_i = bit_at(bs_byte, bs_k, m_lsb);
      end else begin
        if (bs_k < 8) miso_i = bit_at(bs_byte, bs_k, m_lsb);
        bs_k++;
      end
    end
    prev_sck = sck_o;
  end

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // master transfer; returns after ss_no rises again
  task automatic run_master(input logic cpol, input logic cpha, input logic lsb,
                            input logic [1:0] rate, input logic [7:0] tx,
                            input logic [7:0] sl_tx, input string req);
    logic [7:0] r;
    reg_write(2'd0, {2'b01, lsb, 1'b1, cpol, cpha, rate});
    @(negedge clk);
    chk({req, " R4 idle sck"}, sck_o, cpol);
    m_cpol = cpol; m_cpha = cpha; m_lsb = lsb; bs_byte = sl_tx;
    bs_k = 0; cap_k = 0; edge_n = 0; cap = 0;
    miso_i = cpha ? 1'b0 : bit_at(sl_tx, 0, lsb);
    prev_sck = sck_o; mon_on = 1;
    reg_write(2'd2, tx);
    chk({req, " R2 ss low"}, ss_no, 0);
    while (ss_no == 1'b0) @(negedge clk);
    @(negedge clk);
    mon_on = 0;
    chk({req, " R3/R4 mosi byte"}, cap, tx);
    chk({req, " R4 edges"}, edge_n, 16);
    reg_read(2'd2, r);
    chk({req, " R2 rx byte"}, r, sl_tx);
    reg_read(2'd1, r);
    chk({req, " R6 done flag"}, r[7], 1);
  endtask

  task automatic clear_status();
    logic [7:0] r;
    reg_write(2'd1, 8'h00);
    reg_read(2'd1, r);
    chk("R6/R7 cleared", r & 8'hC0, 0);
  endtask

  task automatic t_reset();
    logic [7:0] r;
    reg_read(2'd0, r);
    chk("R1 ctrl", r, 0);
    reg_read(2'd1, r);
    chk("R1 status", r & 8'hC0, 0);
    chk("R1 ss_no", ss_no, 1);
    chk("R1 irq", irq, 0);
    chk("R1 oe", {sck_oe, mosi_oe, miso_oe}, 0);
  endtask

  task automatic t_modes();
    run_master(0, 0, 0, 2'd0, 8'hA5, 8'h3C, "mode0 msb");
    clear_status();
    run_master(0, 1, 1, 2'd0, 8'h81, 8'h6E, "mode1 lsb");
    clear_status();
    run_master(1, 0, 1, 2'd0, 8'h17, 8'hF0, "mode2 lsb");
    clear_status();
    run_master(1, 1, 0, 2'd0, 8'hC2, 8'h59, "mode3 msb");
    clear_status();
  endtask

  task automatic t_rates();
    for (int rc = 0; rc < 4; rc++) begin
      int exp_half;
      exp_half = (rc == 0) ? 2 : (rc == 1) ? 8 : (rc == 2) ? 32 : 64;
      run_master(0, 0, 0, 2'(rc), 8'h5A, 8'h96, "rate");
      chk("R5 half period", t_e2 - t_e1, exp_half);
      clear_status();
    end
  endtask

  task automatic t_collision();
    logic [7:0] r;
    reg_write(2'd0, 8'h51); // enabled master, rate 1
    m_cpol = 0; m_cpha = 0; m_lsb = 0; bs_byte = 8'h24;
    bs_k = 0; cap_k = 0; edge_n = 0; cap = 0;
    miso_i = bit_at(8'h24, 0, 0);
    prev_sck = sck_o; mon_on = 1;
    reg_write(2'd2, 8'hE7);
    repeat (20) @(negedge clk);
    reg_write(2'd2, 8'h18);
    reg_read(2'd1, r);
    chk("R7 wcol set", r[6], 1);
    while (ss_no == 1'b0) @(negedge clk);
    @(negedge clk);
    mon_on = 0;
    chk("R7 byte in flight kept", cap, 8'hE7);
    reg_read(2'd2, r);
    chk("R7 rx unaffected", r, 8'h24);
    reg_write(2'd1, 8'hC0);
    reg_read(2'd1, r);
    chk("R6/R7 write of ones keeps flags", r & 8'hC0, 8'hC0);
    reg_write(2'd1, 8'h40);
    reg_read(2'd1, r);
    chk("R6 bit7=0 clears done only", r & 8'hC0, 8'h40);
    clear_status();
  endtask

  task automatic t_irq();
    run_master(0, 0, 0, 2'd0, 8'h11, 8'h22, "irq");
    ser_en = 1'b1;
    reg_write(2'd0, 8'h50);
    chk("R8 irq ie=0", irq, 0);
    reg_write(2'd0, 8'hD0);
    chk("R8 irq all set", irq, 1);
    ser_en = 1'b0;
    #1 chk("R8 irq ext=0", irq, 0);
    ser_en = 1'b1;
    reg_write(2'd1, 8'h00);
    chk("R8 irq flag clear", irq, 0);
    ser_en = 1'b0;
    reg_write(2'd0, 8'h50);
  endtask

  task automatic t_slave(input logic cpol, input logic cpha, input logic lsb,
                         input logic [7:0] pre, input logic [7:0] mtx);
    logic [7:0] r, got;
    got = 0;
    sck_i = cpol; ss_ni = 1'b1;
    reg_write(2'd0, {2'b01, lsb, 1'b0, cpol, cpha, 2'b11});
    reg_write(2'd2, pre);
    repeat (4) @(negedge clk);
    chk("R10 miso hi-z when deselected", miso_oe, 0);
    ss_ni = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10 miso driven when selected", miso_oe, 1);
    for (int k = 0; k < 8; k++) begin
      if (!cpha) mosi_i = bit_at(mtx, k, lsb);
      repeat (8) @(negedge clk);
      sck_i = ~cpol;
      if (cpha) mosi_i = bit_at(mtx, k, lsb);
      repeat (8) @(negedge clk);
      got[lsb ? k : 7-k] = miso_o;
      sck_i = cpol;
    end
    repeat (8) @(negedge clk);
    ss_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 slave returns preload", got, pre);
    reg_read(2'd2, r);
    chk("R9 slave rx byte", r, mtx);
    reg_read(2'd1, r);
    chk("R9 slave done flag", r[7], 1);
    chk("R10 miso hi-z after deselect", miso_oe, 0);
    clear_status();
  endtask

  task automatic t_disabled();
    logic [7:0] r;
    reg_write(2'd0, 8'h10); // master, not enabled
    reg_write(2'd2, 8'h99);
    repeat (40) @(negedge clk);
    chk("R11 ss stays high", ss_no, 1);
    chk("R11 outputs off", {sck_oe, mosi_oe, miso_oe}, 0);
    reg_read(2'd1, r);
    chk("R11 no completion", r & 8'hC0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_rates();
    t_collision();
    t_irq();
    t_slave(0, 0, 0, 8'hB4, 8'h4D);
    t_slave(1, 1, 1, 8'h63, 8'hA8);
    t_disabled();
    finished = 1;
    summary();
  end
endmodule